// File: doc/BRIEF.md
# Byte-Reversed Halfword Store Unit

This unit runs one indexed store instruction that writes a halfword in little-endian byte order. A 32-bit instruction word arrives with a valid/ready handshake. The unit drives three register indices from that word to a combinational register-file read port and gets back three 64-bit operands. It adds a base operand and an index operand to form the effective address. The base is a literal zero when the base field is zero. The unit then issues one two-byte write request to a byte-addressed memory port and holds it there until the memory accepts it.

The unit also owns a single load-reservation entry. Surrounding logic sets the entry with an address. The entry covers an aligned 8-byte granule. A store that writes any byte inside that granule clears the entry in the same cycle the store is issued. The program counter advances by 4 when the memory accepts the write. Any other instruction word produces a one-cycle illegal pulse and no memory traffic.

Top module: `hbrev_store_unit`

## Requirements
- R1: A word is recognised when bits [31:26] equal 31 and bits [10:1] equal 918 (bit 0 is the MSB-first bit 31 of the big-endian numbering). Bit [0] is ignored. A recognised word that is accepted issues exactly one write.
- R2: An accepted word that is not recognised drives `illegal` high for exactly the cycle after acceptance. It issues no write and leaves the program counter unchanged.
- R3: While a word is presented, the read-port indices equal its fields: source = bits [25:21], base = bits [20:16], index = bits [15:11].
- R4: The effective address is the base operand plus the index operand. When the base field is 0, a literal zero is used in place of register 0.
- R5: The effective address is the low 32 bits of the 64-bit sum, so the address wraps modulo 2^32.
- R6: `mem_wlane0` (the byte at EA) carries source bits [7:0]. `mem_wlane1` (the byte at EA+1) carries source bits [15:8]. Source bits [63:16] have no effect.
- R7: The write request appears the cycle after acceptance. It stays valid with a stable address and stable lanes until `mem_wready`. `insn_ready` is low while a request is pending.
- R8: The program counter resets to `PC_RESET` and increases by 4 on the cycle after each accepted memory write. It is unchanged at all other times.
- R9: With tracking enabled, a pending reservation is cleared when the store is issued if either EA or EA+1 falls in the reservation's aligned 8-byte granule. A clear in the same cycle as a set takes priority.
- R10: A reservation is kept when neither written byte is in its granule, or when tracking is disabled. While tracking is disabled, `resv_set` is ignored.
- R11: Unaligned addresses, including a halfword that crosses a granule boundary, are stored without any fault.
- R12: After reset, `insn_ready` is 1, and `mem_wvalid`, `illegal` and `resv_valid` are 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_ready | output | 1 | Unit can take an instruction |
| insn_word | input | 32 | Instruction word |
| rf_idx_s | output | 5 | Source register index |
| rf_idx_a | output | 5 | Base register index |
| rf_idx_b | output | 5 | Index register index |
| rf_data_s | input | 64 | Source register value |
| rf_data_a | input | 64 | Base register value |
| rf_data_b | input | 64 | Index register value |
| mem_wvalid | output | 1 | Write request valid |
| mem_wready | input | 1 | Memory accepts write |
| mem_waddr | output | 32 | Byte address EA |
| mem_wlane0 | output | 8 | Byte written at EA |
| mem_wlane1 | output | 8 | Byte written at EA+1 |
| illegal | output | 1 | One-cycle pulse for an unhandled word |
| pc | output | 64 | Program counter |
| resv_enable | input | 1 | Reservation tracking enabled |
| resv_set | input | 1 | Create a reservation |
| resv_set_addr | input | 32 | Address of the new reservation |
| resv_valid | output | 1 | Reservation pending |
| resv_addr | output | 32 | Reserved address |

## Verification
The assertions assume that the register-file port returns operands combinationally in the cycle the word is offered. They also assume that `mem_wready` is only sampled as meaningful while a request is pending. The stimulus raises `mem_wready` only while `mem_wvalid` is high and drops it right after the handshake. The stimulus also never pulses `resv_set` in the same cycle that a store is accepted, so the ordering of set against clear is not exercised by the directed tests. Operands are written into the bench's register model before each word is offered and are held stable until the word has been accepted.

// File: rtl/hbrev_pkg.sv
package hbrev_pkg;

  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned XLEN     = 64;
  localparam logic [5:0]  OPC_MAIN = 6'd31;
  localparam logic [9:0]  OPC_EXT  = 10'd918;

  typedef struct packed {
    logic [5:0] opcd;
    logic [4:0] src;
    logic [4:0] base;
    logic [4:0] idx;
    logic [9:0] ext;
    logic       rec;
  } insn_t;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
  } lanes_t;

  // Record bit takes no part in recognition.
  function automatic logic is_target(insn_t w);
    logic unused_rec;
    unused_rec = w.rec;
    return (w.opcd == OPC_MAIN) && (w.ext == OPC_EXT);
  endfunction

  // Base field 0 selects literal zero; result truncated to the address width.
  function automatic logic [ADDR_W-1:0] eff_addr(logic [4:0] base_f,
                                                  logic [XLEN-1:0] base_v,
                                                  logic [XLEN-1:0] idx_v);
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] s;
    b = (base_f == 5'd0) ? '0 : base_v;
    s = b + idx_v;
    return s[ADDR_W-1:0];
  endfunction

  // Only the low halfword of the source is used.
  function automatic lanes_t store_lanes(logic [XLEN-1:0] src_v);
    lanes_t l;
    l.lo = src_v[7:0];
    l.hi = src_v[15:8];
    return l;
  endfunction

endpackage

// File: rtl/hbrev_decode.sv
module hbrev_decode
  import hbrev_pkg::*;
(
  input  logic [31:0] word,
  output logic [4:0]  src_f,
  output logic [4:0]  base_f,
  output logic [4:0]  idx_f,
  output logic        match
);
  insn_t w;
  always_comb begin
    w      = insn_t'(word);
    src_f  = w.src;
    base_f = w.base;
    idx_f  = w.idx;
    match  = is_target(w);
  end
endmodule

// File: rtl/hbrev_wr_port.sv
module hbrev_wr_port #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    lane0_in,
  input  logic [7:0]    lane1_in,
  input  logic          wready,
  output logic          wvalid,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wlane0,
  output logic [7:0]    wlane1,
  output logic          fire
);
  assign fire = wvalid && wready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wvalid <= 1'b0;
      waddr  <= '0;
      wlane0 <= '0;
      wlane1 <= '0;
    end else if (load) begin
      wvalid <= 1'b1;
      waddr  <= addr_in;
      wlane0 <= lane0_in;
      wlane1 <= lane1_in;
    end else if (fire) begin
      wvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/hbrev_resv.sv
module hbrev_resv #(
  parameter int unsigned AW      = 32,
  parameter int unsigned GRAN_LG = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          set,
  input  logic [AW-1:0] set_addr,
  input  logic          probe,
  input  logic [AW-1:0] probe_addr,
  output logic          valid,
  output logic [AW-1:0] addr,
  output logic          hit_ev
);
  localparam int unsigned TAG_W = AW - GRAN_LG;

  logic [AW-1:0]    probe_next;
  logic [TAG_W-1:0] tag_res, tag_p0, tag_p1;

  always_comb begin
    probe_next = probe_addr + {{(AW-1){1'b0}}, 1'b1};
    tag_res    = addr[AW-1:GRAN_LG];
    tag_p0     = probe_addr[AW-1:GRAN_LG];
    tag_p1     = probe_next[AW-1:GRAN_LG];
    hit_ev     = enable && valid && probe && ((tag_p0 == tag_res) || (tag_p1 == tag_res));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
    end else if (hit_ev) begin
      valid <= 1'b0;
    end else if (enable && set) begin
      valid <= 1'b1;
      addr  <= set_addr;
    end
  end
endmodule

// File: rtl/hbrev_store_unit.sv
module hbrev_store_unit
  import hbrev_pkg::*;
#(
  parameter int unsigned        PC_W     = 64,
  parameter logic [PC_W-1:0]    PC_RESET = '0,
  parameter int unsigned        GRAN_LG  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  output logic              insn_ready,
  input  logic [31:0]       insn_word,
  output logic [4:0]        rf_idx_s,
  output logic [4:0]        rf_idx_a,
  output logic [4:0]        rf_idx_b,
  input  logic [XLEN-1:0]   rf_data_s,
  input  logic [XLEN-1:0]   rf_data_a,
  input  logic [XLEN-1:0]   rf_data_b,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wlane0,
  output logic [7:0]        mem_wlane1,
  output logic              illegal,
  output logic [PC_W-1:0]   pc,
  input  logic              resv_enable,
  input  logic              resv_set,
  input  logic [ADDR_W-1:0] resv_set_addr,
  output logic              resv_valid,
  output logic [ADDR_W-1:0] resv_addr
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  // named internal events
  logic              accept_ev;
  logic              issue_ev;
  logic              reject_ev;
  logic              fire_ev;
  logic              resv_hit_ev;
  logic              dec_match;
  logic [ADDR_W-1:0] ea;
  lanes_t            lanes;

  hbrev_decode u_dec (
    .word   (insn_word),
    .src_f  (rf_idx_s),
    .base_f (rf_idx_a),
    .idx_f  (rf_idx_b),
    .match  (dec_match)
  );

  always_comb begin
    insn_ready = !mem_wvalid;
    accept_ev  = insn_valid && insn_ready;
    issue_ev   = accept_ev && dec_match;
    reject_ev  = accept_ev && !dec_match;
    ea         = eff_addr(rf_idx_a, rf_data_a, rf_data_b);
    lanes      = store_lanes(rf_data_s);
  end

  hbrev_wr_port #(.AW(ADDR_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue_ev),
    .addr_in  (ea),
    .lane0_in (lanes.lo),
    .lane1_in (lanes.hi),
    .wready   (mem_wready),
    .wvalid   (mem_wvalid),
    .waddr    (mem_waddr),
    .wlane0   (mem_wlane0),
    .wlane1   (mem_wlane1),
    .fire     (fire_ev)
  );

  hbrev_resv #(.AW(ADDR_W), .GRAN_LG(GRAN_LG)) u_resv (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (resv_enable),
    .set        (resv_set),
    .set_addr   (resv_set_addr),
    .probe      (issue_ev),
    .probe_addr (ea),
    .valid      (resv_valid),
    .addr       (resv_addr),
    .hit_ev     (resv_hit_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= PC_RESET;
      illegal <= 1'b0;
    end else begin
      illegal <= reject_ev;
      if (fire_ev) pc <= pc + PC_STEP;
    end
  end
endmodule

// File: rtl/hbrev_store_chk.sv
module hbrev_store_chk #(
  parameter int unsigned PC_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            insn_ready,
  input logic            illegal,
  input logic            mem_wvalid,
  input logic            mem_wready,
  input logic [31:0]     mem_waddr,
  input logic [7:0]      mem_wlane0,
  input logic [7:0]      mem_wlane1,
  input logic [PC_W-1:0] pc,
  input logic            resv_valid,
  input logic            issue_ev,
  input logic            reject_ev,
  input logic            resv_hit_ev
);
  // R7
  wreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr)
                                     && $stable(mem_wlane0) && $stable(mem_wlane1)));

  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> !insn_ready);

  // R7
  issue_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ev |=> mem_wvalid);

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid && mem_wready) |=> (pc == $past(pc) + PC_W'(4)));

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wvalid && mem_wready) |=> $stable(pc));

  // R2
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> (illegal && !mem_wvalid));

  // R2
  illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({issue_ev, reject_ev}));

  // R9
  resv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resv_hit_ev |=> !resv_valid);
endmodule

bind hbrev_store_unit hbrev_store_chk #(.PC_W(PC_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .insn_ready  (insn_ready),
  .illegal     (illegal),
  .mem_wvalid  (mem_wvalid),
  .mem_wready  (mem_wready),
  .mem_waddr   (mem_waddr),
  .mem_wlane0  (mem_wlane0),
  .mem_wlane1  (mem_wlane1),
  .pc          (pc),
  .resv_valid  (resv_valid),
  .issue_ev    (issue_ev),
  .reject_ev   (reject_ev),
  .resv_hit_ev (resv_hit_ev)
);

// File: tb/hbrev_store_unit_tb_top.sv
module hbrev_store_unit_tb_top;
  localparam logic [63:0] PC0 = 64'h0000_0000_0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic        insn_ready;
  logic [31:0] insn_word = '0;
  logic [4:0]  rf_idx_s, rf_idx_a, rf_idx_b;
  logic [63:0] rf_data_s, rf_data_a, rf_data_b;
  logic        mem_wvalid;
  logic        mem_wready = 1'b0;
  logic [31:0] mem_waddr;
  logic [7:0]  mem_wlane0, mem_wlane1;
  logic        illegal;
  logic [63:0] pc;
  logic        resv_enable = 1'b1;
  logic        resv_set = 1'b0;
  logic [31:0] resv_set_addr = '0;
  logic        resv_valid;
  logic [31:0] resv_addr;

  logic [63:0] rf [32];
  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  assign rf_data_s = rf[rf_idx_s];
  assign rf_data_a = rf[rf_idx_a];
  assign rf_data_b = rf[rf_idx_b];

  hbrev_store_unit #(.PC_RESET(PC0)) dut_i (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn_word(insn_word), .rf_idx_s(rf_idx_s), .rf_idx_a(rf_idx_a), .rf_idx_b(rf_idx_b),
    .rf_data_s(rf_data_s), .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_waddr(mem_waddr),
    .mem_wlane0(mem_wlane0), .mem_wlane1(mem_wlane1), .illegal(illegal), .pc(pc),
    .resv_enable(resv_enable), .resv_set(resv_set), .resv_set_addr(resv_set_addr),
    .resv_valid(resv_valid), .resv_addr(resv_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int opc, input int s, input int a, input int b,
                                     input int xo, input int rc);
    return (32'(opc) << 26) | (32'(s) << 21) | (32'(a) << 16) | (32'(b) << 11)
         | (32'(xo) << 1) | 32'(rc);
  endfunction

  // Offer one word, expect a write; hold off ready for `stall` cycles.
  task automatic run_store(input logic [31:0] w, input logic [31:0] ea, input logic [7:0] l0,
                           input logic [7:0] l1, input int stall, input bit exp_resv,
                           input string tag);
    logic [63:0] pc_b;
    pc_b = pc;
    @(negedge clk);
    insn_word = w; insn_valid = 1'b1;
    #1;
    chk(rf_idx_s == w[25:21] && rf_idx_a == w[20:16] && rf_idx_b == w[15:11],
        {"R3 ", tag}, {49'd0, rf_idx_s, rf_idx_a, rf_idx_b}, {49'd0, w[25:11]});
    @(negedge clk);
    insn_valid = 1'b0;
    chk(mem_wvalid === 1'b1, {"R1 ", tag}, 64'(mem_wvalid), 64'd1);
    chk(mem_waddr === ea, {"R4 ", tag}, 64'(mem_waddr), 64'(ea));
    chk(mem_wlane0 === l0 && mem_wlane1 === l1, {"R6 ", tag},
        {48'd0, mem_wlane1, mem_wlane0}, {48'd0, l1, l0});
    chk(insn_ready === 1'b0, {"R7 ", tag}, 64'(insn_ready), 64'd0);
    chk(resv_valid === exp_resv, {"R9/R10 ", tag}, 64'(resv_valid), 64'(exp_resv));
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(mem_wvalid === 1'b1 && mem_waddr === ea && pc === pc_b, {"R7 stall ", tag},
          64'(mem_waddr), 64'(ea));
    end
    mem_wready = 1'b1;
    @(negedge clk);
    mem_wready = 1'b0;
    chk(mem_wvalid === 1'b0, {"R7 done ", tag}, 64'(mem_wvalid), 64'd0);
    chk(pc === pc_b + 64'd4, {"R8 ", tag}, pc, pc_b + 64'd4);
  endtask

  task automatic run_illegal(input logic [31:0] w, input string tag);
    logic [63:0] pc_b;
    pc_b = pc;
    @(negedge clk);
    insn_word = w; insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    chk(illegal === 1'b1 && mem_wvalid === 1'b0, {"R2 ", tag},
        {62'd0, illegal, mem_wvalid}, 64'd2);
    @(negedge clk);
    chk(illegal === 1'b0 && mem_wvalid === 1'b0 && pc === pc_b, {"R2 after ", tag}, pc, pc_b);
  endtask

  task automatic reserve(input logic [31:0] a);
    @(negedge clk);
    resv_set = 1'b1; resv_set_addr = a;
    @(negedge clk);
    resv_set = 1'b0;
  endtask

  task automatic t_reset();
    chk(insn_ready === 1'b1 && mem_wvalid === 1'b0 && illegal === 1'b0 && resv_valid === 1'b0,
        "R12 reset outputs", {60'd0, insn_ready, mem_wvalid, illegal, resv_valid}, 64'h8);
    chk(pc === PC0, "R12/R8 reset pc", pc, PC0);
  endtask

  task automatic t_decode();
    run_store(mk(31, 3, 1, 2, 918, 0), 32'h2010, 8'hEF, 8'hBE, 0, 1'b0, "basic");
    run_store(mk(31, 3, 1, 2, 918, 1), 32'h2010, 8'hEF, 8'hBE, 0, 1'b0, "R1 rec bit set");
    run_store(mk(31, 8, 1, 2, 918, 0), 32'h2010, 8'h34, 8'h12, 0, 1'b0, "R6 other source");
  endtask

  task automatic t_addr();
    run_store(mk(31, 3, 0, 2, 918, 0), 32'h0000_0010, 8'hEF, 8'hBE, 0, 1'b0, "R4 base field zero");
    run_store(mk(31, 3, 4, 5, 918, 0), 32'h0000_0010, 8'hEF, 8'hBE, 0, 1'b0, "R5 wrap");
  endtask

  task automatic t_stall();
    run_store(mk(31, 3, 1, 2, 918, 0), 32'h2010, 8'hEF, 8'hBE, 3, 1'b0, "R7 stall");
  endtask

  task automatic t_illegal();
    run_illegal(mk(31, 3, 1, 2, 919, 0), "ext off by one");
    run_illegal(mk(30, 3, 1, 2, 918, 0), "wrong primary");
    run_illegal(mk(31, 3, 1, 2, 407, 0), "plain halfword store");
  endtask

  task automatic t_resv();
    reserve(32'h2014);
    chk(resv_valid === 1'b1 && resv_addr === 32'h2014, "R9 set", 64'(resv_addr), 64'h2014);
    run_store(mk(31, 3, 1, 2, 918, 0), 32'h2010, 8'hEF, 8'hBE, 0, 1'b0, "R9 low byte hit");
    reserve(32'h3008);
    run_store(mk(31, 3, 7, 6, 918, 0), 32'h3007, 8'hEF, 8'hBE, 0, 1'b0, "R9 R11 high byte hit");
    reserve(32'h3008);
    run_store(mk(31, 3, 1, 2, 918, 0), 32'h2010, 8'hEF, 8'hBE, 0, 1'b1, "R10 miss");
    resv_enable = 1'b0;
    run_store(mk(31, 3, 7, 6, 918, 0), 32'h3007, 8'hEF, 8'hBE, 0, 1'b1, "R10 disabled");
    reserve(32'h5000);
    chk(resv_addr === 32'h3008, "R10 set ignored when disabled", 64'(resv_addr), 64'h3008);
    resv_enable = 1'b1;
    run_store(mk(31, 3, 6, 6, 918, 0), 32'h0000_000E, 8'hEF, 8'hBE, 1, 1'b1, "R11 odd miss");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 64'h1111_0000_0000_0000 + 64'(i);
    rf[0] = 64'hDEAD_0000_0000_1000;
    rf[1] = 64'h0000_0000_0000_2000;
    rf[2] = 64'h0000_0000_0000_0010;
    rf[3] = 64'hFFFF_FFFF_FFFF_BEEF;
    rf[4] = 64'h0000_0001_FFFF_FFF0;
    rf[5] = 64'h0000_0000_0000_0020;
    rf[6] = 64'h0000_0000_0000_0007;
    rf[7] = 64'h0000_0000_0000_3000;
    rf[8] = 64'hA5A5_5A5A_0000_1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_addr();
    t_stall();
    t_illegal();
    t_resv();
    ended = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule